// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block receives asynchronous serial frames on a single line. Each frame is a low start bit, eight data bits sent least significant bit first, one parity bit and a high stop bit. A bit-rate engine outside the block supplies a tick at eight times the bit rate. The receiver finds a start bit, samples every bit once near its middle, and checks the parity and stop bits. It then places the byte in a one-byte holding buffer.

Software reads the byte and a status byte. The status byte reports whether a frame is in progress, whether the buffer holds unread data, and three error conditions at fixed positions. Together the three errors form the mask 0xE0. A read strobe empties the buffer and clears the errors. The interrupt output is high while unread data is waiting. After the stop bit has been sampled, the receiver goes straight back to looking for the next start bit.

Top module: `async_rx_status`

## Requirements
- R1: After reset, `status_o`, `data_o` and `irq_o` are all zero, and an idle high line with ticks running leaves them at zero.
- R2: A low level seen on a tick begins a frame. That tick is tick 0 of the start bit, and every bit is sampled on its fourth tick (tick 3). `status_o[1]` is 1 while a frame is being received and 0 otherwise.
- R3: If the line is high again at the start bit's sample point, the start is dropped as noise: no byte is stored and no flag other than `status_o[1]` changes.
- R4: Data bits arrive least significant first. When the stop bit has been sampled, the byte appears on `data_o`, `status_o[3]` (buffer full) is set, and `irq_o` follows `status_o[3]`.
- R5: `par_odd_i` = 0 selects even parity and 1 selects odd parity, counted over the eight data bits plus the parity bit. A mismatch sets `status_o[7]`.
- R6: A stop bit sampled as 0 sets `status_o[5]` (framing error). The byte is still stored.
- R7: A frame that completes while `status_o[3]` is already set sets `status_o[6]` (overrun). The unread byte on `data_o` is kept, and the new byte is discarded.
- R8: A one-cycle `rd_i` pulse clears `status_o[3]`, `status_o[5]`, `status_o[6]` and `status_o[7]`. The error mask 0xE0 then reads zero.
- R9: A new start bit that begins right at the end of a stop bit, with no idle time between frames, is received correctly.
- R10: `status_o` bits 0, 2 and 4 always read 0. An error bit is only ever set together with `status_o[3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at eight times the bit rate |
| rd_i | input | 1 | Read strobe; empties the buffer and clears the errors |
| par_odd_i | input | 1 | Parity select: 0 even, 1 odd |
| data_o | output | 8 | Last received byte |
| status_o | output | 8 | Status: bit1 active, bit3 full, bit5 framing, bit6 overrun, bit7 parity |
| irq_o | output | 1 | High while the buffer holds unread data |

## Verification
Random bytes sent under both parity settings show whether the bit order and the sampling point are correct. A byte with a set bit in only one position would reveal a swapped or shifted data path. Frames with a flipped parity bit are mixed with frames whose stop bit is low, and together they show that the parity and framing flags are independent. A short low pulse on an idle line separates real start detection from noise rejection. Two frames sent back to back, once without a read between them and once with a read, separate overrun from the immediate return to start hunting.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned OVS      = 8;
  localparam int unsigned STAT_W   = 8;
  // status positions
  localparam int unsigned ACT_BIT  = 1;
  localparam int unsigned FULL_BIT = 3;
  localparam int unsigned FERR_BIT = 5;
  localparam int unsigned OVR_BIT  = 6;
  localparam int unsigned PERR_BIT = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 1'b1;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= 1'b1;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import async_rx_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned OV  = OVS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic          par_odd_i,
  output logic          active_o,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          ferr_o,
  output logic          perr_o
);
  localparam int unsigned CNT_W = (OV > 1) ? $clog2(OV) : 1;
  localparam int unsigned IDX_W = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CNT_W-1:0] SMP  = CNT_W'(OV/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OV - 1);
  localparam logic [IDX_W-1:0] LBIT = IDX_W'(DW - 1);

  rx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sh_q;
  logic             pbit_q;

  wire smp_w = tick_i && (cnt_q == SMP);
  wire end_w = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      done_o  <= 1'b0;
      byte_o  <= '0;
      ferr_o  <= 1'b0;
      perr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      unique case (state_q)
        ST_IDLE: if (tick_i && !rxd_i) begin
          state_q <= ST_START;
          cnt_q   <= CNT_W'(1);  // detection tick is tick 0
        end
        ST_START: begin
          if (smp_w && rxd_i) state_q <= ST_IDLE;  // noise
          else if (end_w) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA: begin
          if (smp_w) sh_q <= {rxd_i, sh_q[DW-1:1]};
          if (end_w) begin
            if (idx_q == LBIT) state_q <= ST_PAR;
            else               idx_q   <= idx_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (smp_w) pbit_q  <= rxd_i;
          if (end_w) state_q <= ST_STOP;
        end
        ST_STOP: if (smp_w) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          byte_o  <= sh_q;
          ferr_o  <= !rxd_i;
          perr_o  <= ((^sh_q) ^ pbit_q) != par_odd_i;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign active_o = (state_q != ST_IDLE);
endmodule

// File: rtl/rx_status_buf.sv
module rx_status_buf
  import async_rx_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SW = STAT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          ferr_i,
  input  logic          perr_i,
  input  logic          active_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic [SW-1:0] status_o,
  output logic          irq_o
);
  logic full_q, ferr_q, perr_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_q <= 1'b0;
      ferr_q <= 1'b0;
      perr_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (rd_i) begin
        full_q <= 1'b0;
        ferr_q <= 1'b0;
        perr_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (done_i) begin
        if (full_q && !rd_i) ovr_q <= 1'b1;  // keep unread byte
        else begin
          data_o <= byte_i;
          full_q <= 1'b1;
          ferr_q <= ferr_i;
          perr_q <= perr_i;
        end
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ACT_BIT]  = active_i;
    status_o[FULL_BIT] = full_q;
    status_o[FERR_BIT] = ferr_q;
    status_o[OVR_BIT]  = ovr_q;
    status_o[PERR_BIT] = perr_q;
  end

  assign irq_o = full_q;
endmodule

// File: rtl/async_rx_status.sv
module async_rx_status
  import async_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick_i,
  input  logic              rd_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] data_o,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  logic              rxd_s;
  logic              frame_active;
  logic              frame_done;
  logic [DATA_W-1:0] frame_byte;
  logic              frame_ferr;
  logic              frame_perr;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  rx_frame_fsm #(.DW(DATA_W), .OV(OVS)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rxd_i    (rxd_s),
    .tick_i   (tick_i),
    .par_odd_i(par_odd_i),
    .active_o (frame_active),
    .done_o   (frame_done),
    .byte_o   (frame_byte),
    .ferr_o   (frame_ferr),
    .perr_o   (frame_perr)
  );

  rx_status_buf #(.DW(DATA_W), .SW(STAT_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (frame_done),
    .byte_i  (frame_byte),
    .ferr_i  (frame_ferr),
    .perr_i  (frame_perr),
    .active_i(frame_active),
    .rd_i    (rd_i),
    .data_o  (data_o),
    .status_o(status_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/async_rx_status_chk.sv
module async_rx_status_chk
  import async_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              done_i,
  input logic [DATA_W-1:0] byte_i,
  input logic [DATA_W-1:0] data_o,
  input logic [STAT_W-1:0] status_o
);
  // R8
  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !done_i |=> !status_o[FULL_BIT] && status_o[7:5] == 3'b000);

  // R7
  a_r7_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && status_o[FULL_BIT] && !rd_i |=> status_o[OVR_BIT] && $stable(data_o));

  // R4
  a_r4_byte_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !status_o[FULL_BIT] |=> status_o[FULL_BIT] && data_o == $past(byte_i));

  // R10
  a_r10_err_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|status_o[7:5]) |-> status_o[FULL_BIT]);

  // R9: hunting resumes as the frame completes
  a_r9_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !status_o[ACT_BIT]);
endmodule

bind async_rx_status async_rx_status_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .rd_i    (rd_i),
  .done_i  (frame_done),
  .byte_i  (frame_byte),
  .data_o  (data_o),
  .status_o(status_o)
);

// File: tb/async_rx_status_tb_top.sv
`timescale 1ns/1ps
module async_rx_status_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 8 * TICK_DIV;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rxd_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic [7:0] data_o;
  logic [7:0] status_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int tdiv = 0;

  always #2 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    tick_i <= (tdiv == TICK_DIV - 1);
  end

  async_rx_status dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i), .tick_i(tick_i),
    .rd_i(rd_i), .par_odd_i(par_odd_i),
    .data_o(data_o), .status_o(status_o), .irq_o(irq_o)
  );

  function automatic logic good_par(input logic [7:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

  function automatic logic [7:0] exp_stat(input logic fe, input logic ov, input logic pe);
    return 8'h08 | (8'(fe) << 5) | (8'(ov) << 6) | (8'(pe) << 7);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    rxd_i = 1'b1;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_rd();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  // prev_exp >= 0: check and read the previous byte inside this start bit
  task automatic send_frame(input logic [7:0] b, input logic pbit, input logic stop,
                            input int prev_exp);
    rxd_i = 1'b0;
    repeat (2) @(negedge clk_i);
    if (prev_exp >= 0) begin
      check("R9 prev byte", data_o, 8'(prev_exp));
      pulse_rd();
      repeat (BIT_CLK - 3) @(negedge clk_i);
    end else repeat (BIT_CLK - 2) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      rxd_i = b[i];
      repeat (BIT_CLK) @(negedge clk_i);
      if (i == 3) check("R2 active in frame", {7'd0, status_o[1]}, 8'h01);
    end
    rxd_i = pbit;
    repeat (BIT_CLK) @(negedge clk_i);
    rxd_i = stop;
    // low stop is cut short so the line is not taken as a new start
    repeat (stop ? BIT_CLK : 20) @(negedge clk_i);
    rxd_i = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [7:0] b, b2;
    logic odd, bp, bs;
    void'($urandom(32'h1d2c_5eed));
    repeat (5) @(negedge clk_i);
    check("R1 reset status", status_o, 8'h00);
    check("R1 reset data", data_o, 8'h00);
    check("R1 reset irq", {7'd0, irq_o}, 8'h00);
    rst_ni = 1'b1;
    idle(200);
    check("R1 idle status", status_o, 8'h00);

    // noise start: low for two ticks only
    rxd_i = 1'b0;
    repeat (8) @(negedge clk_i);
    idle(60);
    check("R3 noise no byte", status_o, 8'h00);
    check("R3 noise irq", {7'd0, irq_o}, 8'h00);

    // single-bit patterns for bit order
    par_odd_i = 1'b0;
    send_frame(8'h01, good_par(8'h01, 1'b0), 1'b1, -1);
    idle(2);
    check("R4 lsb first", data_o, 8'h01);
    check("R4 full irq", {7'd0, irq_o}, 8'h01);
    check("R2 active cleared", {7'd0, status_o[1]}, 8'h00);
    pulse_rd();
    check("R8 read clears", status_o, 8'h00);
    send_frame(8'h80, good_par(8'h80, 1'b0), 1'b1, -1);
    idle(2);
    check("R4 msb last", data_o, 8'h80);
    pulse_rd();

    // parity modes
    par_odd_i = 1'b1;
    send_frame(8'hA5, good_par(8'hA5, 1'b1), 1'b1, -1);
    idle(2);
    check("R5 odd ok", status_o & 8'hFD, exp_stat(0, 0, 0));
    pulse_rd();
    send_frame(8'hA5, ~good_par(8'hA5, 1'b1), 1'b1, -1);
    idle(2);
    check("R5 odd bad", status_o & 8'hFD, exp_stat(0, 0, 1));
    pulse_rd();
    par_odd_i = 1'b0;

    // framing
    send_frame(8'h3C, good_par(8'h3C, 1'b0), 1'b0, -1);
    idle(40);
    check("R6 framing", status_o & 8'hFD, exp_stat(1, 0, 0));
    check("R6 byte kept", data_o, 8'h3C);
    pulse_rd();
    check("R8 mask clear", status_o & 8'hE0, 8'h00);

    // overrun: two frames, no read
    send_frame(8'h5A, good_par(8'h5A, 1'b0), 1'b1, -1);
    send_frame(8'hC3, good_par(8'hC3, 1'b0), 1'b1, -1);
    idle(2);
    check("R7 overrun flag", status_o & 8'hFD, exp_stat(0, 1, 0));
    check("R7 old byte kept", data_o, 8'h5A);
    pulse_rd();
    check("R8 overrun cleared", status_o, 8'h00);

    // back-to-back with read in next start bit
    send_frame(8'h96, good_par(8'h96, 1'b0), 1'b1, -1);
    send_frame(8'h69, good_par(8'h69, 1'b0), 1'b1, 8'h96);
    idle(2);
    check("R9 second byte", data_o, 8'h69);
    check("R9 no overrun", status_o & 8'hFD, exp_stat(0, 0, 0));
    pulse_rd();

    // random frames
    for (int k = 0; k < 24; k++) begin
      b   = 8'($urandom);
      odd = 1'($urandom);
      bp  = ($urandom % 5) == 0;
      bs  = ($urandom % 6) == 0;
      par_odd_i = odd;
      send_frame(b, good_par(b, odd) ^ bp, ~bs, -1);
      idle(bs ? 40 : 2 + ($urandom % 20));
      check("R4 random byte", data_o, b);
      check("R5/R6 random status", status_o & 8'hFD, exp_stat(bs, 0, bp));
      check("R10 spare bits", status_o & 8'h15, 8'h00);
      pulse_rd();
      check("R8 random clear", status_o & 8'hFD, 8'h00);
    end
    b2 = 8'h00;
    check("R1 final idle", {7'd0, irq_o} | b2, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule